// File: doc/BRIEF.md
# Time Calendar Updater with Alarm

This block holds a running clock and calendar (seconds, minutes, hours, day of week, date, month, two-digit year) and three alarm bytes for seconds, minutes and hours. A one-second tick input moves the time forward by one second. The carry ripples through the calendar, which understands month lengths and leap years over a 00 to 99 year span. After each advance the block compares the new time with the alarm bytes and raises single-cycle event pulses.

All ten bytes share one encoding, either plain binary or packed BCD, chosen by a mode input. The hours byte follows either a 24-hour or a 12-hour convention, and in 12-hour mode bit 7 marks PM. A hold input freezes the counters so that software can load a consistent time through the write port. A registered read port returns any byte.

Top module: `rtc_time_updater`

## Requirements
- R1: When `tick_1s` is high on a rising clock edge, with `set_hold` and `wr_en` low, the seconds byte increases by one at that edge. A read issued on the next cycle returns the new value.
- R2: Carries ripple in order. Seconds wrap from 59 to 0 and step minutes; minutes wrap from 59 to 0 and step hours; hours wrap from 23 to 0 and step the date; the last date of a month wraps to 1 and steps the month; month 12 wraps to 1 and steps the year; year 99 wraps to 00. The day of week (1..7, with 7 wrapping to 1) steps together with the date.
- R3: January, March, May, July, August, October and December have 31 days. April, June, September and November have 30. February has 29 days when the year is divisible by 4 and 28 otherwise.
- R4: With `bin_mode`=1 every byte is plain binary (for example 59 is 0x3B). With `bin_mode`=0 every byte is packed BCD, with tens in bits 7:4 and units in bits 3:0 (59 is 0x59). Advancing follows the selected encoding.
- R5: With `h24_mode`=0 the hours byte holds 1..12 in bits 6:0, and bit 7=1 means PM. The sequence runs 11 AM, 12 PM (0x92 in BCD), 1 PM, and 11 PM (0x91 in BCD) advances to 12 AM (0x12 in BCD) and steps the date.
- R6: While `set_hold` is 1, ticks change no byte and produce no event pulse. Writes still take effect.
- R7: Byte addresses are 0 seconds, 1 minutes, 2 hours, 3 day of week, 4 date, 5 month, 6 year, 7 seconds alarm, 8 minutes alarm and 9 hours alarm. A write lands at the clock edge. A tick in the same cycle as any write is dropped. Writes to addresses 10..15 change nothing, and reads from them return 0. `rd_data` is registered one cycle after `rd_addr`.
- R8: Each completed advance makes `update_done` high for exactly one cycle, two rising edges after the tick edge.
- R9: `alarm_hit` goes high together with `update_done` when the advanced seconds, minutes and hours bytes equal their alarm bytes.
- R10: An alarm byte with bits 7:6 both 1 (0xC0..0xFF) matches any value. A wildcard hours byte alone gives an hourly alarm, and three wildcards give an alarm every second.
- R11: Synchronous reset `rst` sets seconds, minutes, hours and year to 0, day of week, date and month to 1, and every alarm byte to 0. It also clears both pulses and `rd_data`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_1s | input | 1 | One-second advance request |
| set_hold | input | 1 | Freeze counters while 1 |
| bin_mode | input | 1 | 1 binary, 0 BCD |
| h24_mode | input | 1 | 1 24-hour, 0 12-hour with PM bit |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | AW | Write byte address |
| wr_data | input | 8 | Write byte value |
| rd_addr | input | AW | Read byte address |
| rd_data | output | 8 | Registered read value |
| update_done | output | 1 | One-cycle pulse after each advance |
| alarm_hit | output | 1 | One-cycle pulse on alarm match |

## Verification
The advance logic is driven from a table of start times. The table covers a plain seconds step, a full rollover at the end of a century, ends of long, short and February months in leap and common years, and BCD digit carries set against the same values in binary. It also walks the four 12-hour turning points at 11 AM, 12 PM, 11 PM and 12 AM. Each case isolates one carry path or one encoding, so a wrong wrap limit, a misplaced leap rule or a PM flip off by one hour shows in a single byte. Directed cases then separate an exact alarm from a near miss, an hourly wildcard from a wildcard set on the wrong field, and hold and same-cycle writes from a real advance.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int BYTE_W   = 8;
  localparam int NUM_TIME = 7;
  localparam int NUM_REGS = 10;
  localparam int IX_SEC   = 0;
  localparam int IX_MIN   = 1;
  localparam int IX_HR    = 2;
  localparam int IX_DOW   = 3;
  localparam int IX_DATE  = 4;
  localparam int IX_MON   = 5;
  localparam int IX_YR    = 6;
  localparam int IX_ASEC  = 7;
  localparam int NUM_ALM  = 3;

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [6:0]        num_t;

  // Stored byte to binary count, honouring the data mode.
  function automatic num_t to_num(input byte_t v, input logic bin);
    num_t tens;
    num_t ones;
    tens = {3'b000, v[7:4]};
    ones = {3'b000, v[3:0]};
    to_num = bin ? v[6:0] : num_t'(tens * 7'd10 + ones);
  endfunction

  // Binary count back to stored byte.
  function automatic byte_t from_num(input num_t n, input logic bin);
    num_t tens;
    num_t ones;
    tens = n / 7'd10;
    ones = n % 7'd10;
    from_num = bin ? {1'b0, n} : {tens[3:0], ones[3:0]};
  endfunction

  function automatic num_t month_len(input num_t mon, input num_t yr);
    case (mon)
      7'd2:                    month_len = (yr[1:0] == 2'b00) ? 7'd29 : 7'd28;
      7'd4, 7'd6, 7'd9, 7'd11: month_len = 7'd30;
      default:                 month_len = 7'd31;
    endcase
  endfunction
endpackage

// File: rtl/rtc_advance.sv
module rtc_advance
  import rtc_pkg::*;
(
  input  logic                        bin_mode,
  input  logic                        h24_mode,
  input  logic [NUM_TIME-1:0][7:0]    cur_i,
  output logic [NUM_TIME-1:0][7:0]    nxt_o
);
  num_t s, m, h, w, d, mo, y;
  num_t h12_in, h12_out;
  num_t s_n, m_n, h_n, w_n, d_n, mo_n, y_n;
  logic c_s, c_m, c_h, c_d, c_mo;
  logic pm_in, pm_out;

  always_comb begin
    s      = to_num(cur_i[IX_SEC], bin_mode);
    m      = to_num(cur_i[IX_MIN], bin_mode);
    w      = to_num(cur_i[IX_DOW], bin_mode);
    d      = to_num(cur_i[IX_DATE], bin_mode);
    mo     = to_num(cur_i[IX_MON], bin_mode);
    y      = to_num(cur_i[IX_YR], bin_mode);
    pm_in  = cur_i[IX_HR][7];
    h12_in = to_num({1'b0, cur_i[IX_HR][6:0]}, bin_mode);
    if (h24_mode) h = to_num(cur_i[IX_HR], bin_mode);
    else          h = ((h12_in == 7'd12) ? 7'd0 : h12_in) + (pm_in ? 7'd12 : 7'd0);

    // carry chain, always a single second step
    c_s  = (s >= 7'd59);
    s_n  = c_s ? 7'd0 : s + 7'd1;
    c_m  = c_s && (m >= 7'd59);
    m_n  = c_s ? (c_m ? 7'd0 : m + 7'd1) : m;
    c_h  = c_m && (h >= 7'd23);
    h_n  = c_m ? (c_h ? 7'd0 : h + 7'd1) : h;
    c_d  = c_h && (d >= month_len(mo, y));
    d_n  = c_h ? (c_d ? 7'd1 : d + 7'd1) : d;
    w_n  = c_h ? ((w >= 7'd7) ? 7'd1 : w + 7'd1) : w;
    c_mo = c_d && (mo >= 7'd12);
    mo_n = c_d ? (c_mo ? 7'd1 : mo + 7'd1) : mo;
    y_n  = c_mo ? ((y >= 7'd99) ? 7'd0 : y + 7'd1) : y;

    pm_out  = (h_n >= 7'd12);
    h12_out = (h_n == 7'd0) ? 7'd12 : ((h_n > 7'd12) ? h_n - 7'd12 : h_n);

    nxt_o[IX_SEC]  = from_num(s_n, bin_mode);
    nxt_o[IX_MIN]  = from_num(m_n, bin_mode);
    nxt_o[IX_DOW]  = from_num(w_n, bin_mode);
    nxt_o[IX_DATE] = from_num(d_n, bin_mode);
    nxt_o[IX_MON]  = from_num(mo_n, bin_mode);
    nxt_o[IX_YR]   = from_num(y_n, bin_mode);
    if (h24_mode) nxt_o[IX_HR] = from_num(h_n, bin_mode);
    else          nxt_o[IX_HR] = {pm_out, from_num(h12_out, bin_mode)[6:0]};
  end
endmodule

// File: rtl/rtc_alarm_cmp.sv
module rtc_alarm_cmp
  import rtc_pkg::*;
(
  input  logic [NUM_ALM-1:0][7:0] time_i,   // sec, min, hr
  input  logic [NUM_ALM-1:0][7:0] alarm_i,  // sec, min, hr
  output logic                    match_o
);
  logic [NUM_ALM-1:0] field_ok;

  for (genvar g = 0; g < NUM_ALM; g++) begin : g_field
    // top two bits set: field is a wildcard
    assign field_ok[g] = (alarm_i[g][7:6] == 2'b11) || (alarm_i[g] == time_i[g]);
  end

  assign match_o = &field_ok;
endmodule

// File: rtl/rtc_time_updater.sv
module rtc_time_updater
  import rtc_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_1s,
  input  logic          set_hold,
  input  logic          bin_mode,
  input  logic          h24_mode,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [7:0]    rd_data,
  output logic          update_done,
  output logic          alarm_hit
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(NUM_REGS - 1);

  // Register file held in flops: the advance reads all time bytes at once.
  logic [NUM_REGS-1:0][7:0] regs_q;
  logic [NUM_TIME-1:0][7:0] time_cur, time_nxt;
  logic [NUM_ALM-1:0][7:0]  alm_time, alm_set;
  logic do_adv, adv_q, match;

  assign do_adv = tick_1s && !set_hold && !wr_en;

  for (genvar g = 0; g < NUM_TIME; g++) begin : g_cur
    assign time_cur[g] = regs_q[g];
  end
  for (genvar g = 0; g < NUM_ALM; g++) begin : g_alm
    assign alm_time[g] = regs_q[g];
    assign alm_set[g]  = regs_q[IX_ASEC + g];
  end

  rtc_advance i_adv (
    .bin_mode (bin_mode),
    .h24_mode (h24_mode),
    .cur_i    (time_cur),
    .nxt_o    (time_nxt)
  );

  rtc_alarm_cmp i_alm (
    .time_i  (alm_time),
    .alarm_i (alm_set),
    .match_o (match)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      regs_q      <= '0;
      regs_q[IX_DOW]  <= 8'd1;
      regs_q[IX_DATE] <= 8'd1;
      regs_q[IX_MON]  <= 8'd1;
      adv_q       <= 1'b0;
      update_done <= 1'b0;
      alarm_hit   <= 1'b0;
      rd_data     <= '0;
    end else begin
      adv_q       <= do_adv;
      update_done <= adv_q;
      alarm_hit   <= adv_q && match;
      if (wr_en) begin
        if (wr_addr <= LAST_ADDR) regs_q[wr_addr] <= wr_data;
      end else if (do_adv) begin
        for (int i = 0; i < NUM_TIME; i++) regs_q[i] <= time_nxt[i];
      end
      rd_data <= (rd_addr <= LAST_ADDR) ? regs_q[rd_addr] : 8'h00;
    end
  end

  assert_sec_step_R1: assert property (@(posedge clk) disable iff (rst)
    (tick_1s && !set_hold && !wr_en && bin_mode && regs_q[IX_SEC] < 8'd59)
    |=> regs_q[IX_SEC] == $past(regs_q[IX_SEC]) + 8'd1);

  assert_hold_freeze_R6: assert property (@(posedge clk) disable iff (rst)
    (set_hold && !wr_en) |=> $stable(regs_q[IX_SEC]) && $stable(regs_q[IX_HR]));

  assert_write_lands_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == '0) |=> regs_q[IX_SEC] == $past(wr_data));

  assert_alarm_with_done_R9: assert property (@(posedge clk) disable iff (rst)
    alarm_hit |-> update_done);

  assert_all_wild_fires_R10: assert property (@(posedge clk) disable iff (rst)
    (adv_q && regs_q[7][7:6] == 2'b11 && regs_q[8][7:6] == 2'b11 && regs_q[9][7:6] == 2'b11)
    |=> alarm_hit);
endmodule

// File: tb/test_rtc_time_updater.sv
`timescale 1ns/1ps
module test_rtc_time_updater;
  logic clk = 0, rst = 1, tick_1s = 0, set_hold = 0, bin_mode = 0, h24_mode = 1;
  logic wr_en = 0;
  logic [3:0] wr_addr = 0, rd_addr = 0;
  logic [7:0] wr_data = 0, rd_data;
  logic update_done, alarm_hit;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rtc_time_updater i_rtc_time_updater (
    .clk(clk), .rst(rst), .tick_1s(tick_1s), .set_hold(set_hold),
    .bin_mode(bin_mode), .h24_mode(h24_mode), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
    .rd_data(rd_data), .update_done(update_done), .alarm_hit(alarm_hit)
  );

  // {bin, h24, start sec..year, expected sec..year}
  localparam int NV = 15;
  localparam logic [113:0] VEC [NV] = '{
    {1'b0, 1'b1, 56'h00_00_00_01_01_01_00, 56'h01_00_00_01_01_01_00}, // R1
    {1'b0, 1'b1, 56'h59_59_23_07_31_12_99, 56'h00_00_00_01_01_01_00}, // R2
    {1'b0, 1'b1, 56'h59_59_23_03_28_02_23, 56'h00_00_00_04_01_03_23}, // R3 common
    {1'b0, 1'b1, 56'h59_59_23_03_28_02_24, 56'h00_00_00_04_29_02_24}, // R3 leap
    {1'b0, 1'b1, 56'h59_59_23_04_29_02_24, 56'h00_00_00_05_01_03_24}, // R3
    {1'b0, 1'b1, 56'h59_59_23_02_30_04_05, 56'h00_00_00_03_01_05_05}, // R3 30-day
    {1'b0, 1'b1, 56'h09_00_00_01_01_01_00, 56'h10_00_00_01_01_01_00}, // R4 bcd
    {1'b1, 1'b1, 56'h09_00_00_01_01_01_00, 56'h0A_00_00_01_01_01_00}, // R4 bin
    {1'b1, 1'b1, 56'h3B_3B_17_07_1F_0C_63, 56'h00_00_00_01_01_01_00}, // R4 R2
    {1'b0, 1'b0, 56'h59_59_11_01_01_01_00, 56'h00_00_92_01_01_01_00}, // R5 11AM
    {1'b0, 1'b0, 56'h59_59_92_01_01_01_00, 56'h00_00_81_01_01_01_00}, // R5 12PM
    {1'b0, 1'b0, 56'h59_59_91_01_01_01_00, 56'h00_00_12_02_02_01_00}, // R5 11PM
    {1'b0, 1'b0, 56'h59_59_12_01_01_01_00, 56'h00_00_01_01_01_01_00}, // R5 12AM
    {1'b1, 1'b0, 56'h3B_3B_8B_01_01_01_00, 56'h00_00_0C_02_02_01_00}, // R5 bin
    {1'b1, 1'b1, 56'h3B_3B_17_02_1F_01_05, 56'h00_00_00_03_01_02_05}  // R3 bin
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); rd_addr = a;
    @(negedge clk); d = rd_data;
  endtask

  // returns pulse values in the cycle they are due and one cycle later
  task automatic tick(output logic dn, output logic al, output logic dn2);
    @(negedge clk); tick_1s = 1;
    @(negedge clk); tick_1s = 0;
    @(negedge clk); dn = update_done; al = alarm_hit;
    @(negedge clk); dn2 = update_done;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    logic [7:0] v;
    logic dn, al, dn2;
    repeat (3) @(negedge clk);
    rst = 0;
    // R11 reset state
    chk("R11 done", {7'b0, update_done}, 8'h00);
    chk("R11 alarm", {7'b0, alarm_hit}, 8'h00);
    for (int i = 0; i < 10; i++) begin
      rd(4'(i), v);
      chk("R11 byte", v, (i >= 3 && i <= 5) ? 8'h01 : 8'h00);
    end

    // table walk: R1..R5, R8
    wr(4'd7, 8'h00); wr(4'd8, 8'h00); wr(4'd9, 8'h7F);
    for (int n = 0; n < NV; n++) begin
      bin_mode = VEC[n][113];
      h24_mode = VEC[n][112];
      for (int k = 0; k < 7; k++) wr(4'(k), VEC[n][111 - 8*k -: 8]);
      tick(dn, al, dn2);
      chk("R8 done pulse", {7'b0, dn}, 8'h01);
      chk("R8 single cycle", {7'b0, dn2}, 8'h00);
      for (int k = 0; k < 7; k++) begin
        rd(4'(k), v);
        chk($sformatf("R2/R5 vector %0d byte %0d", n, k), v, VEC[n][55 - 8*k -: 8]);
      end
    end

    bin_mode = 0; h24_mode = 1;
    // R6 hold
    set_hold = 1;
    wr(4'd0, 8'h05);
    tick(dn, al, dn2);
    chk("R6 no pulse", {7'b0, dn}, 8'h00);
    rd(4'd0, v); chk("R6 frozen", v, 8'h05);
    set_hold = 0;

    // R7 write beats tick
    @(negedge clk); wr_en = 1; wr_addr = 0; wr_data = 8'h20; tick_1s = 1;
    @(negedge clk); wr_en = 0; tick_1s = 0;
    @(negedge clk); chk("R7 tick dropped", {7'b0, update_done}, 8'h00);
    rd(4'd0, v); chk("R7 write wins", v, 8'h20);
    // R7 out-of-range address
    wr(4'd9, 8'h33);
    wr(4'd12, 8'h55);
    rd(4'd12, v); chk("R7 hole reads 0", v, 8'h00);
    rd(4'd9, v);  chk("R7 hole write ignored", v, 8'h33);

    // R9 exact alarm at 00:00:10
    wr(4'd0, 8'h09); wr(4'd1, 8'h00); wr(4'd2, 8'h00);
    wr(4'd7, 8'h10); wr(4'd8, 8'h00); wr(4'd9, 8'h00);
    tick(dn, al, dn2); chk("R9 exact match", {7'b0, al}, 8'h01);
    tick(dn, al, dn2); chk("R9 no match next second", {7'b0, al}, 8'h00);

    // R10 hourly wildcard
    wr(4'd0, 8'h09); wr(4'd2, 8'h05); wr(4'd9, 8'hC0);
    tick(dn, al, dn2); chk("R10 hour wildcard", {7'b0, al}, 8'h01);
    // R10 wildcards on sec/min but hour differs
    wr(4'd7, 8'hFF); wr(4'd8, 8'hFF); wr(4'd9, 8'h06);
    tick(dn, al, dn2); chk("R10 hour mismatch", {7'b0, al}, 8'h00);
    // R10 all wildcards
    wr(4'd7, 8'hFF); wr(4'd8, 8'hC3); wr(4'd9, 8'hE0);
    tick(dn, al, dn2); chk("R10 every second", {7'b0, al}, 8'h01);
    tick(dn, al, dn2); chk("R10 every second again", {7'b0, al}, 8'h01);

    finish_run();
  end
endmodule